// File: doc/BRIEF.md
# Debug Trigger Match and Action Unit

This block keeps a small bank of programmable debug triggers next to a processor pipeline. Each trigger watches one kind of event: a retired instruction's program counter, a load address, a store address, or the data of a store. It compares that event against a stored target value. A trigger that matches raises one of two requests, depending on its action field. One request asks the core to enter debug mode. The other asks for a breakpoint trap to machine mode.

The breakpoint path behaves like a level interrupt. A sticky per-trigger hit flag drives an interrupt line, and software lowers that line by writing zeros to the flags. Breakpoint-action triggers stay quiet while machine interrupts are disabled. They also stay quiet while a global inhibit bit is set. The hardware sets that bit whenever it raises a breakpoint request, so a second trigger cannot overwrite trap state while the handler is still saving it. Debugger-action triggers ignore both of these gates. While the core is already in debug mode, no trigger has any effect.

Top module: `dbg_trig_unit`

## Requirements
- R1: After reset, `dbg_req`, `bkpt_req`, `trig_irq`, `inhibit` and every bit of `hit_flags` are 0, and `req_cause` is 0.
- R2: A trigger matches only when its enable bit is set and it is selected for the event kind. Execute events compare `exe_pc`. Load events compare `ld_addr`. Store events compare `st_data` when the trigger's data-select bit is 1, or `st_addr` when it is 0. A data-select trigger matches no execute or load event.
- R3: A request is registered. It is high for exactly one cycle, the cycle after the event was presented.
- R4: An action value of 0 raises `bkpt_req`. Any nonzero action value raises `dbg_req`. A firing trigger sets its own bit in `hit_flags`.
- R5: While `debug_mode` is 1, a match raises no request and sets no hit flag.
- R6: When a debug-action trigger and a breakpoint-action trigger fire in the same cycle, both requests are raised together. `req_cause` gives the debug request priority: 2 means debug, 1 means breakpoint only, 0 means none.
- R7: `trig_irq` is 1 whenever some trigger with action 0 has its hit flag set. Writing `hit_we` with a 0 in a bit of `hit_wdata` clears that flag. Writing a 1 leaves the flag unchanged.
- R8: While `mirq_en` is 0, breakpoint-action triggers neither raise `bkpt_req` nor set their hit flag.
- R9: Debug-action triggers fire regardless of `mirq_en` and of `inhibit`.
- R10: `inhibit` becomes 1 in the same cycle as `bkpt_req`. While it is 1, breakpoint-action triggers do not fire. A pulse on `inh_clr` returns it to 0. If a breakpoint fires in the same cycle, setting takes precedence.
- R11: A hit flag stays set through later events, matching or not, until a hit write clears it.
- R12: A configuration write loads the target, kind bits, data-select, action and enable of the trigger chosen by `cfg_idx` in one cycle. A write whose index is at or above `NUM_TRIG` changes no trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exe_valid | input | 1 | An instruction retires this cycle |
| exe_pc | input | XLEN | Program counter of the retiring instruction |
| ld_valid | input | 1 | A load access this cycle |
| ld_addr | input | XLEN | Load address |
| st_valid | input | 1 | A store access this cycle |
| st_addr | input | XLEN | Store address |
| st_data | input | XLEN | Store data |
| debug_mode | input | 1 | Core is in debug mode |
| mirq_en | input | 1 | The machine-level trigger interrupt is currently enabled |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Trigger index of the write |
| cfg_target | input | XLEN | Target value to compare |
| cfg_on_exec | input | 1 | Trigger watches execute events |
| cfg_on_load | input | 1 | Trigger watches loads |
| cfg_on_store | input | 1 | Trigger watches stores |
| cfg_data_sel | input | 1 | Compare store data instead of an address |
| cfg_action | input | ACT_W | 0 = breakpoint, nonzero = debug mode |
| cfg_enable | input | 1 | Trigger enable |
| hit_we | input | 1 | Hit flag write strobe |
| hit_wdata | input | NUM_TRIG | 0 clears a flag, 1 keeps it |
| inh_clr | input | 1 | Clears the inhibit bit |
| dbg_req | output | 1 | Debug-mode entry request |
| bkpt_req | output | 1 | Breakpoint trap request |
| req_cause | output | 2 | Prioritized cause of this cycle's request |
| trig_irq | output | 1 | Level trigger interrupt |
| hit_flags | output | NUM_TRIG | Sticky per-trigger hit flags |
| inhibit | output | 1 | Global breakpoint-trigger inhibit |

## Verification
Exact matches are driven on each event kind, and each is paired with a near miss on the same kind. An equal value presented on the wrong kind, a disabled trigger, and a store whose address rather than data equals a data-select target each show that every compare gate is separate. The same matching PC is then replayed under debug mode, under interrupt disable and under a set inhibit bit. Each replay tells whether the debug and breakpoint paths are gated independently. An out-of-range configuration write followed by the original match shows that no trigger was aliased.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

  localparam int ACT_W = 4;

  typedef struct packed {
    logic             on_exec;
    logic             on_load;
    logic             on_store;
    logic             data_sel;
    logic [ACT_W-1:0] action;
    logic             enable;
  } trig_mode_t;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_BKPT = 2'd1,
    CAUSE_DBG  = 2'd2
  } req_cause_e;

endpackage

// File: rtl/dbg_trig_slot.sv
module dbg_trig_slot
  import dbg_trig_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_load,
  input  logic [XLEN-1:0] cfg_target,
  input  trig_mode_t      cfg_mode,
  input  logic            exe_valid,
  input  logic [XLEN-1:0] exe_pc,
  input  logic            ld_valid,
  input  logic [XLEN-1:0] ld_addr,
  input  logic            st_valid,
  input  logic [XLEN-1:0] st_addr,
  input  logic [XLEN-1:0] st_data,
  input  logic            allow_bp,
  input  logic            allow_dbg,
  input  logic            hit_we,
  input  logic            hit_keep,
  output logic            fire_bp,
  output logic            fire_dbg,
  output logic            hit,
  output logic            bp_hit
);

  logic [XLEN-1:0] target_q;
  trig_mode_t      mode_q;
  logic            hit_q;
  logic            hit_d;
  logic            exe_m;
  logic            ld_m;
  logic            st_m;
  logic            match;
  logic            is_bp;
  logic [XLEN-1:0] st_val;

  // configuration storage, loaded with an explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q <= '0;
      mode_q   <= '0;
    end else if (cfg_load) begin
      target_q <= cfg_target;
      mode_q   <= cfg_mode;
    end
  end

  // compare stage
  always_comb begin
    st_val = mode_q.data_sel ? st_data : st_addr;
    exe_m  = mode_q.on_exec  && exe_valid && !mode_q.data_sel && (exe_pc  == target_q);
    ld_m   = mode_q.on_load  && ld_valid  && !mode_q.data_sel && (ld_addr == target_q);
    st_m   = mode_q.on_store && st_valid  && (st_val == target_q);
    match  = mode_q.enable && (exe_m || ld_m || st_m);
    is_bp  = (mode_q.action == '0);
    fire_bp  = match &&  is_bp && allow_bp;
    fire_dbg = match && !is_bp && allow_dbg;
  end

  // sticky hit flag: a firing sets it, only a zero write clears it
  always_comb begin
    hit_d = hit_q;
    if (hit_we && !hit_keep) begin
      hit_d = 1'b0;
    end
    if (fire_bp || fire_dbg) begin
      hit_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
    end else begin
      hit_q <= hit_d;
    end
  end

  assign hit    = hit_q;
  assign bp_hit = hit_q && is_bp;

endmodule

// File: rtl/dbg_trig_arbiter.sv
module dbg_trig_arbiter
  import dbg_trig_pkg::*;
#(
  parameter int NUM_TRIG = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                debug_mode,
  input  logic                mirq_en,
  input  logic                inh_clr,
  input  logic [NUM_TRIG-1:0] fire_bp,
  input  logic [NUM_TRIG-1:0] fire_dbg,
  input  logic [NUM_TRIG-1:0] bp_hit,
  output logic                allow_bp,
  output logic                allow_dbg,
  output logic                dbg_req,
  output logic                bkpt_req,
  output logic [1:0]          req_cause,
  output logic                trig_irq,
  output logic                inhibit
);

  logic       any_bp;
  logic       any_dbg;
  logic       inh_q;
  logic       inh_d;
  logic       dbg_q;
  logic       bp_q;
  req_cause_e cause_d;
  req_cause_e cause_q;

  assign allow_dbg = !debug_mode;
  assign allow_bp  = !debug_mode && mirq_en && !inh_q;

  always_comb begin
    any_bp  = |fire_bp;
    any_dbg = |fire_dbg;
    if (any_dbg) begin
      cause_d = CAUSE_DBG;
    end else if (any_bp) begin
      cause_d = CAUSE_BKPT;
    end else begin
      cause_d = CAUSE_NONE;
    end
    inh_d = inh_q;
    if (inh_clr) begin
      inh_d = 1'b0;
    end
    if (any_bp) begin
      inh_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_q   <= 1'b0;
      bp_q    <= 1'b0;
      cause_q <= CAUSE_NONE;
      inh_q   <= 1'b0;
    end else begin
      dbg_q   <= any_dbg;
      bp_q    <= any_bp;
      cause_q <= cause_d;
      inh_q   <= inh_d;
    end
  end

  assign dbg_req   = dbg_q;
  assign bkpt_req  = bp_q;
  assign req_cause = cause_q;
  assign inhibit   = inh_q;
  assign trig_irq  = |bp_hit;

endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
  import dbg_trig_pkg::*;
#(
  parameter int  NUM_TRIG = 4,
  parameter int  XLEN     = 32,
  localparam int IDX_W    = $clog2(NUM_TRIG) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                exe_valid,
  input  logic [XLEN-1:0]     exe_pc,
  input  logic                ld_valid,
  input  logic [XLEN-1:0]     ld_addr,
  input  logic                st_valid,
  input  logic [XLEN-1:0]     st_addr,
  input  logic [XLEN-1:0]     st_data,
  input  logic                debug_mode,
  input  logic                mirq_en,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [XLEN-1:0]     cfg_target,
  input  logic                cfg_on_exec,
  input  logic                cfg_on_load,
  input  logic                cfg_on_store,
  input  logic                cfg_data_sel,
  input  logic [ACT_W-1:0]    cfg_action,
  input  logic                cfg_enable,
  input  logic                hit_we,
  input  logic [NUM_TRIG-1:0] hit_wdata,
  input  logic                inh_clr,
  output logic                dbg_req,
  output logic                bkpt_req,
  output logic [1:0]          req_cause,
  output logic                trig_irq,
  output logic [NUM_TRIG-1:0] hit_flags,
  output logic                inhibit
);

  trig_mode_t          wr_mode;
  logic [NUM_TRIG-1:0] slot_load;
  logic [NUM_TRIG-1:0] fire_bp;
  logic [NUM_TRIG-1:0] fire_dbg;
  logic [NUM_TRIG-1:0] bp_hit;
  logic                allow_bp;
  logic                allow_dbg;

  always_comb begin
    wr_mode.on_exec  = cfg_on_exec;
    wr_mode.on_load  = cfg_on_load;
    wr_mode.on_store = cfg_on_store;
    wr_mode.data_sel = cfg_data_sel;
    wr_mode.action   = cfg_action;
    wr_mode.enable   = cfg_enable;
  end

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_slot
    // index decode; indices at or above NUM_TRIG select nothing
    assign slot_load[g] = cfg_we && (cfg_idx == IDX_W'(g));

    dbg_trig_slot #(.XLEN(XLEN)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_load   (slot_load[g]),
      .cfg_target (cfg_target),
      .cfg_mode   (wr_mode),
      .exe_valid  (exe_valid),
      .exe_pc     (exe_pc),
      .ld_valid   (ld_valid),
      .ld_addr    (ld_addr),
      .st_valid   (st_valid),
      .st_addr    (st_addr),
      .st_data    (st_data),
      .allow_bp   (allow_bp),
      .allow_dbg  (allow_dbg),
      .hit_we     (hit_we),
      .hit_keep   (hit_wdata[g]),
      .fire_bp    (fire_bp[g]),
      .fire_dbg   (fire_dbg[g]),
      .hit        (hit_flags[g]),
      .bp_hit     (bp_hit[g])
    );
  end

  dbg_trig_arbiter #(.NUM_TRIG(NUM_TRIG)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .debug_mode (debug_mode),
    .mirq_en    (mirq_en),
    .inh_clr    (inh_clr),
    .fire_bp    (fire_bp),
    .fire_dbg   (fire_dbg),
    .bp_hit     (bp_hit),
    .allow_bp   (allow_bp),
    .allow_dbg  (allow_dbg),
    .dbg_req    (dbg_req),
    .bkpt_req   (bkpt_req),
    .req_cause  (req_cause),
    .trig_irq   (trig_irq),
    .inhibit    (inhibit)
  );

endmodule

// File: rtl/dbg_trig_unit_chk.sv
module dbg_trig_unit_chk #(
  parameter int NUM_TRIG = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                debug_mode,
  input logic                mirq_en,
  input logic                hit_we,
  input logic                dbg_req,
  input logic                bkpt_req,
  input logic [1:0]          req_cause,
  input logic [NUM_TRIG-1:0] hit_flags,
  input logic                inhibit
);

  assert_dbgmode_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    debug_mode |=> (!dbg_req && !bkpt_req));

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mirq_en |=> !bkpt_req);

  assert_inhibit_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> !bkpt_req);

  assert_inhibit_on_bp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bkpt_req |-> inhibit);

  assert_hit_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_we |=> ((hit_flags & $past(hit_flags)) == $past(hit_flags)));

  assert_cause_dbg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req |-> (req_cause == 2'd2));

  assert_cause_bp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bkpt_req && !dbg_req) |-> (req_cause == 2'd1));

  assert_cause_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bkpt_req && !dbg_req) |-> (req_cause == 2'd0));

endmodule

bind dbg_trig_unit dbg_trig_unit_chk #(.NUM_TRIG(NUM_TRIG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .debug_mode (debug_mode),
  .mirq_en    (mirq_en),
  .hit_we     (hit_we),
  .dbg_req    (dbg_req),
  .bkpt_req   (bkpt_req),
  .req_cause  (req_cause),
  .hit_flags  (hit_flags),
  .inhibit    (inhibit)
);

// File: tb/dbg_trig_unit_test.sv
`timescale 1ns/1ps
module dbg_trig_unit_test;

  localparam int NT = 4;
  localparam int XL = 32;
  localparam int IW = $clog2(NT) + 1;

  logic          clk;
  logic          rst_n;
  logic          exe_valid, ld_valid, st_valid;
  logic [XL-1:0] exe_pc, ld_addr, st_addr, st_data;
  logic          debug_mode, mirq_en;
  logic          cfg_we;
  logic [IW-1:0] cfg_idx;
  logic [XL-1:0] cfg_target;
  logic          cfg_on_exec, cfg_on_load, cfg_on_store, cfg_data_sel, cfg_enable;
  logic [3:0]    cfg_action;
  logic          hit_we;
  logic [NT-1:0] hit_wdata;
  logic          inh_clr;
  logic          dbg_req, bkpt_req, trig_irq, inhibit;
  logic [1:0]    req_cause;
  logic [NT-1:0] hit_flags;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  dbg_trig_unit #(.NUM_TRIG(NT), .XLEN(XL)) uut (
    .clk(clk), .rst_n(rst_n),
    .exe_valid(exe_valid), .exe_pc(exe_pc),
    .ld_valid(ld_valid), .ld_addr(ld_addr),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
    .debug_mode(debug_mode), .mirq_en(mirq_en),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_target(cfg_target),
    .cfg_on_exec(cfg_on_exec), .cfg_on_load(cfg_on_load), .cfg_on_store(cfg_on_store),
    .cfg_data_sel(cfg_data_sel), .cfg_action(cfg_action), .cfg_enable(cfg_enable),
    .hit_we(hit_we), .hit_wdata(hit_wdata), .inh_clr(inh_clr),
    .dbg_req(dbg_req), .bkpt_req(bkpt_req), .req_cause(req_cause),
    .trig_irq(trig_irq), .hit_flags(hit_flags), .inhibit(inhibit)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(string req, bit e_dbg, bit e_bp, logic [1:0] e_cause,
                         logic [NT-1:0] e_hit, bit e_irq, bit e_inh);
    chk(req, "dbg_req",   32'(dbg_req),   32'(e_dbg));
    chk(req, "bkpt_req",  32'(bkpt_req),  32'(e_bp));
    chk(req, "req_cause", 32'(req_cause), 32'(e_cause));
    chk(req, "hit_flags", 32'(hit_flags), 32'(e_hit));
    chk(req, "trig_irq",  32'(trig_irq),  32'(e_irq));
    chk(req, "inhibit",   32'(inhibit),   32'(e_inh));
  endtask

  task automatic cfg(int idx, logic [31:0] tgt, bit ex, bit ld, bit st, bit ds,
                     logic [3:0] act, bit en);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_target = tgt;
    cfg_on_exec = ex; cfg_on_load = ld; cfg_on_store = st;
    cfg_data_sel = ds; cfg_action = act; cfg_enable = en;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // kind: 0 execute, 1 load, 2 store; outputs are sampled on return
  task automatic ev(int kind, logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    exe_valid = (kind == 0); exe_pc  = a;
    ld_valid  = (kind == 1); ld_addr = a;
    st_valid  = (kind == 2); st_addr = a; st_data = d;
    @(negedge clk);
    exe_valid = 1'b0; ld_valid = 1'b0; st_valid = 1'b0;
  endtask

  task automatic hit_write(logic [NT-1:0] d);
    @(negedge clk);
    hit_we = 1'b1; hit_wdata = d;
    @(negedge clk);
    hit_we = 1'b0;
  endtask

  task automatic inh_clear();
    @(negedge clk);
    inh_clr = 1'b1;
    @(negedge clk);
    inh_clr = 1'b0;
  endtask

  task automatic release_all(string req);
    hit_write('0);
    inh_clear();
    chk_all(req, 0, 0, 2'd0, 4'b0000, 0, 0);
  endtask

  task automatic t_reset();
    chk_all("R1", 0, 0, 2'd0, 4'b0000, 0, 0);
  endtask

  task automatic t_exec_bp();
    cfg(0, 32'h1000, 1, 0, 0, 0, 4'd0, 1);
    ev(0, 32'h1000, 0);
    chk_all("R4", 0, 1, 2'd1, 4'b0001, 1, 1);
    @(negedge clk);
    chk_all("R3", 0, 0, 2'd0, 4'b0001, 1, 1);
    release_all("R7");
  endtask

  task automatic t_mismatch();
    ev(0, 32'h1004, 0);
    chk_all("R2 pc miss", 0, 0, 2'd0, 4'b0000, 0, 0);
    ev(1, 32'h1000, 0);
    chk_all("R2 wrong kind", 0, 0, 2'd0, 4'b0000, 0, 0);
    cfg(0, 32'h1000, 1, 0, 0, 0, 4'd0, 0);
    ev(0, 32'h1000, 0);
    chk_all("R2 disabled", 0, 0, 2'd0, 4'b0000, 0, 0);
    cfg(0, 32'h1000, 1, 0, 0, 0, 4'd0, 1);
  endtask

  task automatic t_load_store();
    cfg(1, 32'h2000, 0, 1, 0, 0, 4'd1, 1);
    ev(1, 32'h2000, 0);
    chk_all("R2 load", 1, 0, 2'd2, 4'b0010, 0, 0);
    cfg(2, 32'h8000_0000, 0, 0, 1, 1, 4'd0, 1);
    ev(2, 32'h8000_0000, 32'h5);
    chk_all("R2 data not addr", 0, 0, 2'd0, 4'b0010, 0, 0);
    ev(2, 32'h40, 32'h8000_0000);
    chk_all("R2 store data", 0, 1, 2'd1, 4'b0110, 1, 1);
    release_all("R7");
    cfg(2, 32'h3000, 0, 0, 1, 0, 4'd2, 1);
    ev(2, 32'h3000, 32'h0);
    chk_all("R2 store addr", 1, 0, 2'd2, 4'b0100, 0, 0);
    release_all("R7");
    cfg(1, 32'h0, 0, 0, 0, 0, 4'd0, 0);
    cfg(2, 32'h0, 0, 0, 0, 0, 4'd0, 0);
  endtask

  task automatic t_debug_mode();
    debug_mode = 1'b1;
    ev(0, 32'h1000, 0);
    chk_all("R5", 0, 0, 2'd0, 4'b0000, 0, 0);
    debug_mode = 1'b0;
  endtask

  task automatic t_both();
    cfg(3, 32'h1000, 1, 0, 0, 0, 4'd7, 1);
    ev(0, 32'h1000, 0);
    chk_all("R6", 1, 1, 2'd2, 4'b1001, 1, 1);
    release_all("R6");
  endtask

  task automatic t_irq_off();
    mirq_en = 1'b0;
    ev(0, 32'h1000, 0);
    chk_all("R8 R9", 1, 0, 2'd2, 4'b1000, 0, 0);
    cfg(3, 32'h1000, 1, 0, 0, 0, 4'd7, 0);
    ev(0, 32'h1000, 0);
    chk_all("R8", 0, 0, 2'd0, 4'b1000, 0, 0);
    mirq_en = 1'b1;
    release_all("R8");
  endtask

  task automatic t_inhibit();
    cfg(3, 32'h1000, 1, 0, 0, 0, 4'd7, 1);
    ev(0, 32'h1000, 0);
    chk_all("R10 set", 1, 1, 2'd2, 4'b1001, 1, 1);
    hit_write('0);
    chk_all("R10 held", 0, 0, 2'd0, 4'b0000, 0, 1);
    ev(0, 32'h1000, 0);
    chk_all("R10 R9 blocked", 1, 0, 2'd2, 4'b1000, 0, 1);
    inh_clear();
    chk("R10", "inhibit cleared", 32'(inhibit), 32'd0);
    hit_write('0);
    ev(0, 32'h1000, 0);
    chk_all("R10 reopened", 1, 1, 2'd2, 4'b1001, 1, 1);
    release_all("R10");
    cfg(3, 32'h0, 0, 0, 0, 0, 4'd0, 0);
  endtask

  task automatic t_sticky();
    ev(0, 32'h1000, 0);
    chk_all("R11 fire", 0, 1, 2'd1, 4'b0001, 1, 1);
    ev(0, 32'h1004, 0);
    ev(1, 32'h1000, 0);
    chk_all("R11 kept", 0, 0, 2'd0, 4'b0001, 1, 1);
    hit_write('1);
    chk_all("R7 write one", 0, 0, 2'd0, 4'b0001, 1, 1);
    hit_write('0);
    chk_all("R7 write zero", 0, 0, 2'd0, 4'b0000, 0, 1);
    inh_clear();
  endtask

  task automatic t_cfg_range();
    cfg(4, 32'h1000, 1, 0, 0, 0, 4'd0, 0);
    cfg(7, 32'h5555, 0, 1, 0, 0, 4'd3, 0);
    ev(0, 32'h1000, 0);
    chk_all("R12", 0, 1, 2'd1, 4'b0001, 1, 1);
    release_all("R12");
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  initial begin
    rst_n = 1'b0;
    exe_valid = 0; ld_valid = 0; st_valid = 0;
    exe_pc = '0; ld_addr = '0; st_addr = '0; st_data = '0;
    debug_mode = 0; mirq_en = 1;
    cfg_we = 0; cfg_idx = '0; cfg_target = '0;
    cfg_on_exec = 0; cfg_on_load = 0; cfg_on_store = 0;
    cfg_data_sel = 0; cfg_action = '0; cfg_enable = 0;
    hit_we = 0; hit_wdata = '0; inh_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_exec_bp();
    t_mismatch();
    t_load_store();
    t_debug_mode();
    t_both();
    t_irq_off();
    t_inhibit();
    t_sticky();
    t_cfg_range();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

endmodule